// File: doc/BRIEF.md
# Indexed Color Palette Loader

This block holds a color lookup table of 256 entries, each a red, green and blue value of 8 bits, and fills it from a simple register-write bus. Software first writes a starting entry number to the index register, then streams color bytes into the data register. A hidden phase counter routes each byte to red, then green, then blue; once blue is stored the entry number steps on by one (wrapping from 255 to 0) and the phase returns to red. A data write may carry one byte (the low byte of the write data) or a full 32-bit word, which is split into four component bytes taken most significant byte first. The phase keeps advancing across the word, so one word can finish one entry and start the next.

A separate lookup port serves the display scan path. It takes a pixel value as an entry number and returns the packed color one cycle later. Each accepted data write also raises a one-cycle pulse telling the display path that the whole frame needs repainting.

Top module: `color_lut`

## Requirements
- R1: Reset sets every component of every entry to zero, the phase to red, the entry number to 0, the lookup output to zero and the change pulse low.
- R2: An accepted write at offset 0x00 loads bus_wdata[7:0] as the entry number and returns the phase to red, without touching any color.
- R3: Byte-size writes (bus_size = 1) at offset 0x04 store bus_wdata[7:0] into the current entry, the first into red, the second into green, the third into blue.
- R4: Storing blue advances the entry number by one, modulo 256, and returns the phase to red.
- R5: A word-size write (bus_size = 4) at offset 0x04 acts as four component writes in the order bus_wdata[31:24], [23:16], [15:8], [7:0], with the phase advancing after each, so one word may span two entries.
- R6: look_rgb shows the entry selected by look_idx one clock later, red in bits 23:16, green in 15:8, blue in 7:0.
- R7: When a write lands on the looked-up entry in the same clock, look_rgb shows the value from before that write; the new value appears on the following clock.
- R8: pal_changed is high for exactly the clock after each accepted data write and low otherwise; index writes never raise it.
- R9: A write whose size is neither 1 nor 4, or whose offset is neither 0x00 nor 0x04, changes no color, entry number or phase and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Write strobe |
| bus_off | input | 5 | Register byte offset |
| bus_size | input | 3 | Write size in bytes (1 or 4 accepted) |
| bus_wdata | input | 32 | Write data |
| look_idx | input | 8 | Pixel value to translate |
| look_rgb | output | 24 | Packed color of the entry looked up a clock earlier |
| pal_changed | output | 1 | One-clock frame-refresh request after a data write |

## Verification
Every result of this block is due one clock after its cause: a write presented before a rising edge is in the table, and its change pulse is high, by the following falling edge, and a lookup index presented before an edge yields its color at the next falling edge. The bench drives on falling edges and samples on the next falling edge after exactly one rising edge, so each check sees the first value the design can show. The same-clock collision is checked at both edges: the old color after the write's edge, the new one a clock later. Entry number and phase, which have no port, are recovered by looking up where later writes land.

// File: rtl/color_lut_pkg.sv
package color_lut_pkg;

    // Component phase; also the bank number of the component in the store.
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    localparam int unsigned NCOMP = 3;

    function automatic phase_e next_phase(input phase_e ph);
        case (ph)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import color_lut_pkg::*;
#(
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned COMP_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned OFF_W    = 5,
    parameter int unsigned IDX_OFF  = 0,
    parameter int unsigned DATA_OFF = 4,
    localparam int unsigned LANES   = DATA_W / COMP_W,
    localparam int unsigned SIZE_W  = $clog2(LANES) + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_valid,
    input  logic [OFF_W-1:0]              bus_off,
    input  logic [SIZE_W-1:0]             bus_size,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [LANES-1:0]              slot_en,
    output logic [LANES-1:0][IDX_W-1:0]   slot_idx,
    output logic [LANES-1:0][1:0]         slot_comp,
    output logic [LANES-1:0][COMP_W-1:0]  slot_val,
    output logic                          changed
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        phase_e           ph;
        logic             chg;
    } seq_t;

    seq_t st_d, st_q;

    logic size_ok;
    logic idx_hit;
    logic data_hit;
    logic word_wr;

    assign size_ok  = (bus_size == SIZE_W'(1)) || (bus_size == SIZE_W'(LANES));
    assign idx_hit  = bus_valid && size_ok && (bus_off == OFF_W'(IDX_OFF));
    assign data_hit = bus_valid && size_ok && (bus_off == OFF_W'(DATA_OFF));
    assign word_wr  = (bus_size == SIZE_W'(LANES));

    always_comb begin
        st_d      = st_q;
        st_d.chg  = 1'b0;
        slot_en   = '0;
        slot_idx  = '0;
        slot_comp = '0;
        slot_val  = '0;
        if (idx_hit) begin
            st_d.idx = bus_wdata[IDX_W-1:0];
            st_d.ph  = PH_RED;
        end else if (data_hit) begin
            st_d.chg = 1'b1;
            for (int k = 0; k < LANES; k++) begin
                if (word_wr || k == 0) begin
                    slot_en[k]   = 1'b1;
                    slot_idx[k]  = st_d.idx;
                    slot_comp[k] = st_d.ph;
                    slot_val[k]  = word_wr ? bus_wdata[DATA_W-1-k*COMP_W -: COMP_W]
                                           : bus_wdata[COMP_W-1:0];
                    if (st_d.ph == PH_BLU) begin
                        st_d.idx = st_d.idx + IDX_W'(1);
                    end
                    st_d.ph = next_phase(st_d.ph);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.idx <= '0;
            st_q.ph  <= PH_RED;
            st_q.chg <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign changed = st_q.chg;

    a_r4_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ph inside {PH_RED, PH_GRN, PH_BLU});

    a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
        idx_hit |=> (st_q.idx == $past(bus_wdata[IDX_W-1:0])) && (st_q.ph == PH_RED));

    a_r4_blue_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (data_hit && !word_wr && st_q.ph == PH_BLU)
        |=> (st_q.idx == $past(st_q.idx) + IDX_W'(1)) && (st_q.ph == PH_RED));

    a_r5_word_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (data_hit && word_wr) |=> (st_q.ph == next_phase($past(st_q.ph))));

    a_r8_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
        data_hit |=> changed);

    a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid || !size_ok) |=> (!changed && $stable(st_q.idx) && $stable(st_q.ph)));

endmodule

// File: rtl/clut_store.sv
module clut_store
    import color_lut_pkg::*;
#(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned COMP_W = 8,
    parameter int unsigned LANES  = 4,
    localparam int unsigned DEPTH = 1 << IDX_W,
    localparam int unsigned RGB_W = NCOMP * COMP_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES-1:0]              slot_en,
    input  logic [LANES-1:0][IDX_W-1:0]   slot_idx,
    input  logic [LANES-1:0][1:0]         slot_comp,
    input  logic [LANES-1:0][COMP_W-1:0]  slot_val,
    input  logic [IDX_W-1:0]              look_idx,
    output logic [RGB_W-1:0]              look_rgb
);

    for (genvar c = 0; c < NCOMP; c++) begin : g_bank
        logic [COMP_W-1:0] mem_q [DEPTH];
        logic [COMP_W-1:0] rd_d, rd_q;

        always_comb begin
            rd_d = mem_q[look_idx];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int e = 0; e < DEPTH; e++) begin
                    mem_q[e] <= '0;
                end
                rd_q <= '0;
            end else begin
                for (int p = 0; p < LANES; p++) begin
                    if (slot_en[p] && slot_comp[p] == 2'(c)) begin
                        mem_q[slot_idx[p]] <= slot_val[p];
                    end
                end
                rd_q <= rd_d;
            end
        end

        assign look_rgb[(NCOMP-1-c)*COMP_W +: COMP_W] = rd_q;
    end

    // With no write in the previous clock and an unchanged index, the output holds.
    a_r6_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(slot_en) == '0) && $stable(look_idx)) |=> $stable(look_rgb));

endmodule

// File: rtl/color_lut.sv
module color_lut
    import color_lut_pkg::*;
#(
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned COMP_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned OFF_W    = 5,
    parameter int unsigned IDX_OFF  = 0,
    parameter int unsigned DATA_OFF = 4,
    localparam int unsigned LANES   = DATA_W / COMP_W,
    localparam int unsigned SIZE_W  = $clog2(LANES) + 1,
    localparam int unsigned RGB_W   = NCOMP * COMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [OFF_W-1:0]  bus_off,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [IDX_W-1:0]  look_idx,
    output logic [RGB_W-1:0]  look_rgb,
    output logic              pal_changed
);

    logic [LANES-1:0]             slot_en;
    logic [LANES-1:0][IDX_W-1:0]  slot_idx;
    logic [LANES-1:0][1:0]        slot_comp;
    logic [LANES-1:0][COMP_W-1:0] slot_val;

    clut_seq #(
        .IDX_W    (IDX_W),
        .COMP_W   (COMP_W),
        .DATA_W   (DATA_W),
        .OFF_W    (OFF_W),
        .IDX_OFF  (IDX_OFF),
        .DATA_OFF (DATA_OFF)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_off   (bus_off),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .slot_en   (slot_en),
        .slot_idx  (slot_idx),
        .slot_comp (slot_comp),
        .slot_val  (slot_val),
        .changed   (pal_changed)
    );

    clut_store #(
        .IDX_W  (IDX_W),
        .COMP_W (COMP_W),
        .LANES  (LANES)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_en   (slot_en),
        .slot_idx  (slot_idx),
        .slot_comp (slot_comp),
        .slot_val  (slot_val),
        .look_idx  (look_idx),
        .look_rgb  (look_rgb)
    );

    a_r8_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        pal_changed |-> $past(bus_valid));

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!pal_changed && look_rgb == '0));

endmodule

// File: tb/test_color_lut.sv
module test_color_lut;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [4:0]  bus_off = '0;
    logic [2:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [7:0]  look_idx = '0;
    logic [23:0] look_rgb;
    logic        pal_changed;

    int n_chk = 0;
    int n_fail = 0;

    int m_r [256];
    int m_g [256];
    int m_b [256];
    int m_idx = 0;
    int m_ph = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    color_lut i_color_lut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_off     (bus_off),
        .bus_size    (bus_size),
        .bus_wdata   (bus_wdata),
        .look_idx    (look_idx),
        .look_rgb    (look_rgb),
        .pal_changed (pal_changed)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [23:0] packed_of(input int e);
        return {8'(m_r[e]), 8'(m_g[e]), 8'(m_b[e])};
    endfunction

    task automatic model_byte(input int v);
        case (m_ph)
            0: m_r[m_idx] = v;
            1: m_g[m_idx] = v;
            default: begin
                m_b[m_idx] = v;
                m_idx = (m_idx + 1) % 256;
            end
        endcase
        m_ph = (m_ph + 1) % 3;
    endtask

    task automatic model_write(input int off, input int size, input logic [31:0] d);
        if (size != 1 && size != 4) return;
        if (off == 0) begin
            m_idx = d[7:0];
            m_ph = 0;
        end else if (off == 4) begin
            if (size == 1) model_byte(d[7:0]);
            else for (int k = 3; k >= 0; k--) model_byte(d[k*8 +: 8]);
        end
    endtask

    // One write; checks the change pulse one clock later (R8, R9).
    task automatic bus_wr(input int off, input int size, input logic [31:0] d, input string req);
        logic exp_chg;
        exp_chg = (off == 4) && (size == 1 || size == 4);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_off   = 5'(off);
        bus_size  = 3'(size);
        bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        model_write(off, size, d);
        chk({req, " R8 pulse"}, 32'(pal_changed), 32'(exp_chg));
    endtask

    task automatic look(input int e, input string req);
        @(negedge clk);
        look_idx = 8'(e);
        @(negedge clk);
        chk(req, 32'(look_rgb), 32'(packed_of(e)));
    endtask

    task automatic sweep(input string req);
        for (int e = 0; e < 256; e++) look(e, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int e = 0; e < 256; e++) begin
            m_r[e] = 0; m_g[e] = 0; m_b[e] = 0;
        end
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 pulse low", 32'(pal_changed), 32'd0);
        chk("R1 lookup zero", 32'(look_rgb), 32'd0);
        rst_n = 1'b1;
        sweep("R1 entries cleared");

        // R3, R4, R6: fill whole table with byte writes, index wraps at the end
        bus_wr(0, 1, 32'h0, "R2");
        for (int k = 0; k < 768; k++) begin
            bus_wr(4, 1, 32'((k * 29 + 11) & 255) | 32'hA5A5_0000, "R3");
        end
        sweep("R3 R4 R6 byte fill");
        bus_wr(4, 1, 32'hAB, "R4");
        look(0, "R4 wrap to entry 0 red");

        // R8: pulse drops after a single write
        @(negedge clk);
        chk("R8 pulse one clock", 32'(pal_changed), 32'd0);

        // R2: index write with word size, no color change, no pulse
        bus_wr(0, 4, 32'h1234_56FD, "R2");
        look(8'hFD, "R2 colors untouched");
        // R5: words from red phase crossing 255 -> 0
        for (int w = 0; w < 6; w++) begin
            bus_wr(4, 4, 32'h0102_0304 * (w + 1) + 32'h5000_0000, "R5");
        end
        for (int e = 8'hFD; e < 8'hFD + 8; e++) look(e % 256, "R5 word from red");
        // R5: words starting in green and blue phases
        bus_wr(0, 1, 32'h40, "R2");
        bus_wr(4, 1, 32'h11, "R3");
        bus_wr(4, 4, 32'hC1C2_C3C4, "R5");
        bus_wr(4, 4, 32'hD1D2_D3D4, "R5");
        bus_wr(4, 4, 32'hE1E2_E3E4, "R5");
        for (int e = 8'h40; e < 8'h46; e++) look(e, "R5 word from green/blue");

        // R9: ignored sizes and offsets
        bus_wr(0, 1, 32'h80, "R2");
        bus_wr(4, 1, 32'h77, "R3");
        bus_wr(4, 2, 32'hFFFF_FFFF, "R9");
        bus_wr(4, 0, 32'hFFFF_FFFF, "R9");
        bus_wr(4, 3, 32'hFFFF_FFFF, "R9");
        bus_wr(8, 4, 32'hFFFF_FFFF, "R9");
        bus_wr(0, 2, 32'h0000_0010, "R9");
        bus_wr(16, 1, 32'h0000_0020, "R9");
        bus_wr(4, 1, 32'h66, "R9 phase kept");
        sweep("R9 nothing changed");

        // R7: write and lookup of the same entry in one clock
        bus_wr(0, 1, 32'h09, "R2");
        begin
            logic [23:0] old_v;
            old_v = packed_of(9);
            @(negedge clk);
            look_idx  = 8'h09;
            bus_valid = 1'b1;
            bus_off   = 5'd4;
            bus_size  = 3'd1;
            bus_wdata = 32'h5A;
            @(negedge clk);
            bus_valid = 1'b0;
            model_write(4, 1, 32'h5A);
            chk("R7 old value first", 32'(look_rgb), 32'(old_v));
            chk("R8 pulse on collision", 32'(pal_changed), 32'd1);
            @(negedge clk);
            chk("R7 new value next", 32'(look_rgb), 32'(packed_of(9)));
        end

        // R1: reset again clears table and phase
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int e = 0; e < 256; e++) begin
            m_r[e] = 0; m_g[e] = 0; m_b[e] = 0;
        end
        m_idx = 0;
        m_ph = 0;
        bus_wr(4, 1, 32'h3C, "R1 phase red after reset");
        sweep("R1 cleared again");

        finish_run();
    end

endmodule